// File: doc/BRIEF.md
# Serial-to-parallel LED shift controller

This peripheral sits on a 32-bit register port and sends frames over a three-wire serial link to a chain of external 8-bit shift registers. The three wires are a data line, a shift clock and a store strobe. The chain holds up to three 8-bit groups. Software enables groups, fills a data register and requests an update. The block then shifts the frame out, with bit 0 going last, and gives one store pulse so that every parallel output changes together.

The block also has an automatic mode, driven by a prescaled timer tick. In this mode it refreshes the chain at one of four rates. While automatic mode is on, some of the low output bits can be handed over to hardware status inputs: two modem bits and two 3-bit PHY fields. Those bits then follow the hardware instead of the CPU data register.

The shift clock runs at the system clock divided by a fixed parameter. The capture edge is selectable. The data line only moves on the edge opposite to the capture edge. A request that arrives while a frame is in flight is remembered and served as soon as that frame ends.

Top module: `led_shift_ctrl`

## Requirements
- R1: After reset, control 0 (offset 0x00) reads 0x8000_0000, and control 1 (0x04), data 0 (0x08), data 1 (0x0C) and the access register (0x10) read zero. The store line is low, and the shift clock idles low.
- R2: The frame length is set by the highest enabled group in control 1 bits [2:0]. It is 8 bits when only bit 0 is set, 16 bits when bit 1 is the highest set bit, and 24 bits when bit 2 is set. With all three bits clear, an update request sends nothing and the block stays idle.
- R3: A write to control 0 with bit 31 set requests a frame. The frame carries data 0 bits [length-1:0], most significant bit first, so data 0 bit 0 is the last bit shifted.
- R4: After the last capture edge of a frame, the store line goes high for exactly one system clock cycle, once per frame.
- R5: Control 0 bit 26 selects the capture edge: 1 means falling, 0 means rising. The shift clock idles at the level opposite to the capture edge's end level, which is high for falling and low for rising. The data line changes only while the shift clock is at that idle level.
- R6: Access register bit 0 reads 1 while a frame is being sent. Any number of requests made during a frame cause exactly one further frame. That frame uses data 0 as it stands when the frame starts.
- R7: In automatic mode (control 1 bit 31 set), control 0 bit 24 hands output bit 0 to modem status bit 0, and control 0 bit 25 hands output bit 1 to modem status bit 1.
- R8: In automatic mode, a nonzero control 0 [28:27] hands output bits 2 to 4 to PHY1 status bits 0 to 2. A nonzero control 1 [16:15] hands output bits 5 to 7 to PHY2 status bits 0 to 2.
- R9: In automatic mode, frames repeat on the tick input with a period of TICK_HZ/2, TICK_HZ/4, TICK_HZ/8 or TICK_HZ/10 ticks, for control 0 [24:23] = 00, 01, 10 and 11 respectively.
- R10: Data 1 stores and reads back all 32 bits. Writes to the access register are ignored, and it keeps reading the busy flag in bit 0 and zero elsewhere.
- R11: With control 1 bit 31 clear, every output bit comes from data 0, whatever the hand-over bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tick | input | 1 | Prescaled timer tick, one cycle wide |
| modem_sts | input | 2 | Modem status bits |
| phy1_sts | input | 3 | PHY1 status bits |
| phy2_sts | input | 3 | PHY2 status bits |
| ser_clk | output | 1 | Shift clock to the chain |
| ser_data | output | 1 | Serial data to the chain |
| ser_store | output | 1 | Store strobe to the chain |

## Verification
The bench decodes the serial wires behaviourally on every clock and checks the frames against a model of the registers it has written. It drives group masks with holes (only group 1 or only group 2 enabled), which a design that counts enabled groups instead of taking the highest would shorten. It sets falling-edge capture, under which a design with the wrong clock polarity captures shifted or inverted words. It bursts several requests into one busy frame, which a queue-based design would turn into extra frames, and it sets the hand-over bits with automatic mode off, where a wrong gate leaks status bits into the frame. In automatic mode it measures the store-to-store spacing at all four rates, which exposes wrong period decoding, and it checks every hardware-owned bit separately.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;

    localparam int GRP_W   = 8;
    localparam int NUM_GRP = 3;
    localparam int FRAME_W = GRP_W * NUM_GRP;

    // word index of each register (byte address bits [4:2])
    localparam logic [2:0] W_CTL0  = 3'd0;
    localparam logic [2:0] W_CTL1  = 3'd1;
    localparam logic [2:0] W_DATA0 = 3'd2;
    localparam logic [2:0] W_DATA1 = 3'd3;
    localparam logic [2:0] W_ACC   = 3'd4;

    localparam logic [31:0] CTL0_RST = 32'h8000_0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_CAPTURE,
        ST_STORE
    } shift_st_e;

    typedef struct packed {
        logic [31:0] ctl0;
        logic [31:0] ctl1;
        logic [31:0] data0;
        logic [31:0] data1;
    } regs_t;

    typedef struct packed {
        logic       auto_en;
        logic       edge_fall;
        logic [1:0] rate;
        logic [1:0] modem_sel;
        logic       phy1_on;
        logic       phy2_on;
        logic [2:0] grp_en;
    } cfg_t;

    function automatic cfg_t decode_cfg(input regs_t r);
        cfg_t c;
        c.auto_en   = r.ctl1[31];
        c.edge_fall = r.ctl0[26];
        c.rate      = r.ctl0[24:23];
        c.modem_sel = r.ctl0[25:24];
        c.phy1_on   = |r.ctl0[28:27];
        c.phy2_on   = |r.ctl1[16:15];
        c.grp_en    = r.ctl1[2:0];
        return c;
    endfunction

    // number of groups in a frame: position of the highest enabled group
    function automatic logic [1:0] frame_groups(input logic [2:0] en);
        if (en[2])      return 2'd3;
        else if (en[1]) return 2'd2;
        else if (en[0]) return 2'd1;
        else            return 2'd0;
    endfunction

    // move the used low bits to the top so the MSB leaves first
    function automatic logic [FRAME_W-1:0] align_frame(input logic [FRAME_W-1:0] f,
                                                       input logic [1:0] n);
        int sh;
        sh = (NUM_GRP - int'(n)) * GRP_W;
        return f << sh;
    endfunction

endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
    import led_shift_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        busy,
    output regs_t       regs,
    output logic [31:0] bus_rdata,
    output logic        sw_req
);

    logic [2:0] word;
    assign word = bus_addr[4:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.ctl0  <= CTL0_RST;
            regs.ctl1  <= '0;
            regs.data0 <= '0;
            regs.data1 <= '0;
        end else if (bus_wr) begin
            case (word)
                W_CTL0:  regs.ctl0  <= bus_wdata;
                W_CTL1:  regs.ctl1  <= bus_wdata;
                W_DATA0: regs.data0 <= bus_wdata;
                W_DATA1: regs.data1 <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign sw_req = bus_wr && (word == W_CTL0) && bus_wdata[31];

    always_comb begin
        case (word)
            W_CTL0:  bus_rdata = regs.ctl0;
            W_CTL1:  bus_rdata = regs.ctl1;
            W_DATA0: bus_rdata = regs.data0;
            W_DATA1: bus_rdata = regs.data1;
            W_ACC:   bus_rdata = {31'd0, busy};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lsc_refresh.sv
module lsc_refresh #(
    parameter int TICK_HZ = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       auto_en,
    input  logic [1:0] rate,
    input  logic       tick,
    output logic       auto_req
);

    localparam int P_2HZ  = TICK_HZ / 2;
    localparam int P_4HZ  = TICK_HZ / 4;
    localparam int P_8HZ  = TICK_HZ / 8;
    localparam int P_10HZ = TICK_HZ / 10;
    localparam int CW     = $clog2(P_2HZ + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        case (rate)
            2'b00:   last = CW'(P_2HZ - 1);
            2'b01:   last = CW'(P_4HZ - 1);
            2'b10:   last = CW'(P_8HZ - 1);
            default: last = CW'(P_10HZ - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !auto_en) begin
            cnt      <= '0;
            auto_req <= 1'b0;
        end else begin
            auto_req <= 1'b0;
            if (tick) begin
                if (cnt >= last) begin
                    cnt      <= '0;
                    auto_req <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lsc_frame_mux.sv
module lsc_frame_mux
    import led_shift_pkg::*;
(
    input  cfg_t               cfg,
    input  logic [FRAME_W-1:0] data0,
    input  logic [1:0]         modem_sts,
    input  logic [2:0]         phy1_sts,
    input  logic [2:0]         phy2_sts,
    output logic [FRAME_W-1:0] frame
);

    for (genvar i = 0; i < FRAME_W; i++) begin : g_bit
        if (i < 2) begin : g_modem
            assign frame[i] = (cfg.auto_en && cfg.modem_sel[i]) ? modem_sts[i] : data0[i];
        end else if (i < 5) begin : g_phy1
            assign frame[i] = (cfg.auto_en && cfg.phy1_on) ? phy1_sts[i-2] : data0[i];
        end else if (i < 8) begin : g_phy2
            assign frame[i] = (cfg.auto_en && cfg.phy2_on) ? phy2_sts[i-5] : data0[i];
        end else begin : g_cpu
            assign frame[i] = data0[i];
        end
    end

endmodule

// File: rtl/lsc_shifter.sv
module lsc_shifter
    import led_shift_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [1:0]         ngrp,
    input  logic [FRAME_W-1:0] frame,
    input  logic               edge_fall,
    output logic               ser_clk,
    output logic               ser_data,
    output logic               ser_store,
    output logic               busy,
    output logic               pend
);

    localparam int DW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam int BW = $clog2(FRAME_W);

    shift_st_e          st;
    logic [DW-1:0]      div;
    logic [BW-1:0]      left;
    logic [FRAME_W-1:0] sh;
    logic               pend_q;
    logic               div_end;

    assign div_end = (div == DW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            div    <= '0;
            left   <= '0;
            sh     <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= req | (pend_q & (st != ST_IDLE));
            case (st)
                ST_IDLE: begin
                    div <= '0;
                    if (pend_q && ngrp != 2'd0) begin
                        st   <= ST_LAUNCH;
                        sh   <= align_frame(frame, ngrp);
                        left <= BW'(int'(ngrp) * GRP_W - 1);
                    end
                end
                ST_LAUNCH: begin
                    if (div_end) begin
                        div <= '0;
                        st  <= ST_CAPTURE;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    if (div_end) begin
                        div <= '0;
                        if (left == '0) begin
                            st <= ST_STORE;
                        end else begin
                            left <= left - 1'b1;
                            sh   <= {sh[FRAME_W-2:0], 1'b0};
                            st   <= ST_LAUNCH;
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st)
            ST_CAPTURE: ser_clk = ~edge_fall;
            default:    ser_clk = edge_fall;
        endcase
    end

    assign ser_data  = sh[FRAME_W-1];
    assign ser_store = (st == ST_STORE);
    assign busy      = (st != ST_IDLE);
    assign pend      = pend_q;

endmodule

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl
    import led_shift_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int TICK_HZ  = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tick,
    input  logic [1:0]  modem_sts,
    input  logic [2:0]  phy1_sts,
    input  logic [2:0]  phy2_sts,
    output logic        ser_clk,
    output logic        ser_data,
    output logic        ser_store
);

    regs_t              regs;
    cfg_t               cfg;
    logic               sw_req;
    logic               auto_req;
    logic               busy;
    logic               pend;
    logic               edge_fall;
    logic [FRAME_W-1:0] frame;

    assign cfg       = decode_cfg(regs);
    assign edge_fall = cfg.edge_fall;

    lsc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .regs      (regs),
        .bus_rdata (bus_rdata),
        .sw_req    (sw_req)
    );

    lsc_refresh #(.TICK_HZ(TICK_HZ)) u_refresh (
        .clk      (clk),
        .rst      (rst),
        .auto_en  (cfg.auto_en),
        .rate     (cfg.rate),
        .tick     (tick),
        .auto_req (auto_req)
    );

    lsc_frame_mux u_mux (
        .cfg       (cfg),
        .data0     (regs.data0[FRAME_W-1:0]),
        .modem_sts (modem_sts),
        .phy1_sts  (phy1_sts),
        .phy2_sts  (phy2_sts),
        .frame     (frame)
    );

    lsc_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .req       (sw_req | auto_req),
        .ngrp      (frame_groups(cfg.grp_en)),
        .frame     (frame),
        .edge_fall (edge_fall),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_store (ser_store),
        .busy      (busy),
        .pend      (pend)
    );

endmodule

// File: rtl/lsc_checker.sv
module lsc_checker (
    input logic clk,
    input logic rst,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_store,
    input logic busy,
    input logic pend,
    input logic edge_fall
);

    a_r4_store_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ser_store |=> !ser_store);

    a_r4_store_in_frame: assert property (@(posedge clk) disable iff (rst)
        ser_store |-> busy);

    a_r5_data_at_launch: assert property (@(posedge clk) disable iff (rst)
        (busy && !$stable(ser_data)) |-> (ser_clk == edge_fall));

    a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ser_clk == edge_fall));

    a_r6_pending_follows: assert property (@(posedge clk) disable iff (rst)
        (ser_store && pend) |=> ##1 busy);

endmodule

bind led_shift_ctrl lsc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_store (ser_store),
    .busy      (busy),
    .pend      (pend),
    .edge_fall (edge_fall)
);

// File: tb/led_shift_ctrl_bench.sv
module led_shift_ctrl_bench;

    localparam logic [4:0] A_CTL0 = 5'h00;
    localparam logic [4:0] A_CTL1 = 5'h04;
    localparam logic [4:0] A_D0   = 5'h08;
    localparam logic [4:0] A_D1   = 5'h0C;
    localparam logic [4:0] A_ACC  = 5'h10;
    localparam int TICK_GAP = 16;
    localparam int TICK_HZ  = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0;
    logic [1:0]  modem_sts = 2'b10;
    logic [2:0]  phy1_sts = 3'b101;
    logic [2:0]  phy2_sts = 3'b011;
    logic        ser_clk, ser_data, ser_store;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    // serial decoder state
    bit          edge_b = 1'b0;
    logic        p_clk = 1'b0, p_data = 1'b0, p_store = 1'b0;
    logic [31:0] mon_word = '0;
    int          mon_bits = 0;
    int          nfr = 0;
    logic [31:0] fr_word [64];
    int          fr_bits [64];
    int          fr_time [64];

    led_shift_ctrl #(.HALF_DIV(2), .TICK_HZ(TICK_HZ)) u_led_shift_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .modem_sts(modem_sts), .phy1_sts(phy1_sts), .phy2_sts(phy2_sts),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_store(ser_store)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        forever begin
            repeat (TICK_GAP - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural decoder of the serial wires, evaluated every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (ser_data !== p_data) begin
                nchk++;
                if (ser_clk !== edge_b) begin
                    nerr++;
                    $display("FAIL R5 data moved off launch level: actual clk=%b expected=%b",
                             ser_clk, edge_b);
                end
            end
            if (ser_clk !== p_clk && ser_clk === !edge_b) begin
                mon_word = {mon_word[30:0], ser_data};
                mon_bits++;
            end
            if (ser_store) begin
                if (p_store) begin
                    nchk++;
                    nerr++;
                    $display("FAIL R4 store longer than one cycle: actual=1 expected=0");
                end else begin
                    fr_word[nfr % 64] = mon_word;
                    fr_bits[nfr % 64] = mon_bits;
                    fr_time[nfr % 64] = cyc;
                    nfr++;
                    mon_word = '0;
                    mon_bits = 0;
                end
            end
        end
        p_clk   = ser_clk;
        p_data  = ser_data;
        p_store = ser_store;
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int quiet = 0;
        repeat (3) @(negedge clk);
        for (int t = 0; t < 4000 && quiet < 2; t++) begin
            rd(A_ACC, v);
            if (v[0] == 1'b0) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic mon_clear();
        mon_word = '0;
        mon_bits = 0;
    endtask

    task automatic one_frame(input string tag, input logic [31:0] ctl0v,
                             input int len, input logic [31:0] exp);
        int base;
        base = nfr;
        wr(A_CTL0, ctl0v | 32'h8000_0000);
        wait_idle();
        chk_eq({tag, " frame count"}, 32'(nfr - base), 32'd1);
        chk_eq({tag, " length"}, 32'(fr_bits[base % 64]), 32'(len));
        chk_eq({tag, " word"}, fr_word[base % 64], exp);
    endtask

    task automatic auto_rate(input string tag, input logic [31:0] ctl0v,
                             input logic [7:0] exp, input int interval);
        int base;
        wr(A_CTL0, ctl0v);
        base = nfr;
        for (int t = 0; t < 20000 && nfr < base + 3; t++) @(negedge clk);
        chk_eq({tag, " R9 interval"},
               32'(fr_time[(base + 2) % 64] - fr_time[(base + 1) % 64]), 32'(interval));
        for (int k = 1; k < 3; k++) begin
            chk_eq({tag, " R7 modem bits"}, {30'd0, fr_word[(base + k) % 64][1:0]}, {30'd0, exp[1:0]});
            chk_eq({tag, " R8 phy bits"}, {26'd0, fr_word[(base + k) % 64][7:2]}, {26'd0, exp[7:2]});
        end
    endtask

    initial begin
        logic [31:0] v;
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CTL0, v); chk_eq("R1 ctl0", v, 32'h8000_0000);
        rd(A_CTL1, v); chk_eq("R1 ctl1", v, 32'h0);
        rd(A_D0, v);   chk_eq("R1 data0", v, 32'h0);
        rd(A_D1, v);   chk_eq("R1 data1", v, 32'h0);
        rd(A_ACC, v);  chk_eq("R1 access", v, 32'h0);
        chk_eq("R1 store low", {31'd0, ser_store}, 32'd0);
        chk_eq("R1 clock idle", {31'd0, ser_clk}, 32'd0);

        // R2 / R3 frame lengths and order
        wr(A_CTL1, 32'h1);
        wr(A_D0, 32'h00FF_12A5);
        one_frame("R2 R3 group0", 32'h0, 8, 32'hA5);
        wr(A_CTL1, 32'h3);
        one_frame("R2 R3 groups01", 32'h0, 16, 32'h12A5);
        wr(A_CTL1, 32'h2);
        one_frame("R2 R3 group1 only", 32'h0, 16, 32'h12A5);
        wr(A_CTL1, 32'h4);
        wr(A_D0, 32'h00AB_CDEF);
        one_frame("R2 R3 group2 only", 32'h0, 24, 32'hABCDEF);

        // R2 no groups enabled: no frame
        wr(A_CTL1, 32'h0);
        base = nfr;
        wr(A_CTL0, 32'h8000_0000);
        repeat (60) @(negedge clk);
        chk_eq("R2 no-group frame count", 32'(nfr - base), 32'd0);
        rd(A_ACC, v); chk_eq("R2 no-group busy", v, 32'h0);

        // R5 falling capture edge
        wr(A_CTL1, 32'h1);
        wr(A_D0, 32'hC3);
        edge_b = 1'b1;
        wr(A_CTL0, 32'h0400_0000);
        repeat (2) @(negedge clk);
        chk_eq("R5 falling idle level", {31'd0, ser_clk}, 32'd1);
        mon_clear();
        one_frame("R5 falling", 32'h0400_0000, 8, 32'hC3);
        edge_b = 1'b0;
        wr(A_CTL0, 32'h0);
        repeat (2) @(negedge clk);
        chk_eq("R5 rising idle level", {31'd0, ser_clk}, 32'd0);
        mon_clear();

        // R6 busy flag and single pending request
        wr(A_D0, 32'h11);
        base = nfr;
        wr(A_CTL0, 32'h8000_0000);
        repeat (2) @(negedge clk);
        rd(A_ACC, v); chk_eq("R6 busy during frame", v, 32'h1);
        wr(A_D0, 32'h22);
        wr(A_CTL0, 32'h8000_0000);
        wr(A_CTL0, 32'h8000_0000);
        wait_idle();
        repeat (20) @(negedge clk);
        chk_eq("R6 frame count", 32'(nfr - base), 32'd2);
        chk_eq("R6 first word", fr_word[base % 64], 32'h11);
        chk_eq("R6 pending word", fr_word[(base + 1) % 64], 32'h22);

        // R10 data1 storage and access register writes ignored
        wr(A_D1, 32'hDEAD_BEEF);
        rd(A_D1, v); chk_eq("R10 data1", v, 32'hDEAD_BEEF);
        wr(A_ACC, 32'hFFFF_FFFF);
        rd(A_ACC, v); chk_eq("R10 access ignored", v, 32'h0);
        rd(A_CTL1, v); chk_eq("R10 ctl1 untouched", v, 32'h1);

        // R11 hand-over bits with automatic mode off
        wr(A_D0, 32'h0);
        wr(A_CTL1, 32'h0000_8001);
        one_frame("R11 cpu only", 32'h0B00_0000, 8, 32'h00);

        // R7 R8 R9 automatic mode: modem=10, phy1=101, phy2=011
        wr(A_CTL1, 32'h8000_8001);
        auto_rate("rate11", 32'h0B80_0000, 8'h76, (TICK_HZ / 10) * TICK_GAP);
        auto_rate("rate10", 32'h0B00_0000, 8'h76, (TICK_HZ / 8) * TICK_GAP);
        wr(A_D0, 32'h01);
        auto_rate("rate01", 32'h0A80_0000, 8'h77, (TICK_HZ / 4) * TICK_GAP);
        auto_rate("rate00", 32'h0A00_0000, 8'h77, (TICK_HZ / 2) * TICK_GAP);

        summary();
        $finish;
    end

endmodule